// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is the target end of a two-wire serial memory. It watches an already-synchronised clock line and data line. It recognises START and STOP conditions and answers a device select byte addressed to it. It then takes a two-byte memory address and either accepts data bytes or returns stored bytes. The block pulls the data line low only through an open-drain enable. That enable is used for acknowledge bits and for zero data bits.

Incoming write data is collected in a one-page buffer. The buffer is committed to an inferred byte array only when a STOP ends the write. The block is then busy for a fixed number of clock cycles and ignores its select byte while busy, so the controller can poll until a select is acknowledged again. A write-lock input discards write data. Reads go through whatever the lock level is. The address counter is kept between transactions, so a current-address read continues from the last access.

Top module: `eeprom_target`

## Requirements
- R1: A select byte is accepted only when its upper seven bits equal binary 1010 followed by the three `chip_addr` strap bits. The last bit is the direction, 0 for write and 1 for read. On any other select byte the block acknowledges nothing and keeps SDA released until the next START or STOP.
- R2: In a write, the block acknowledges the select byte, the high address byte, the low address byte and every data byte, by driving SDA low during the ninth clock. With `write_lock` low, a single data byte followed by STOP is stored at the given address.
- R3: While `write_lock` is 1, data bytes are still acknowledged, but the array keeps its old contents and the STOP starts no busy period.
- R4: A STOP that ends an unlocked write holding at least one data byte starts a busy period of `WRITE_CYCLES` clocks. During that period no select byte is acknowledged. Afterwards, selects are acknowledged again.
- R5: In a page write, consecutive data bytes go to consecutive addresses, and the address wraps within its aligned 64-byte page. All bytes are committed together at STOP.
- R6: A random read, made of a write select, two address bytes, a repeated START and a read select, returns the byte at the loaded address.
- R7: The address counter advances by one for every byte sent. A current-address read (a read select with no address phase) returns the byte at the counter, including after an earlier transaction has ended.
- R8: When the controller acknowledges a read byte, the next sequential byte follows. The counter wraps from the last array address to 0.
- R9: When the controller does not acknowledge a read byte, the block leaves SDA released until STOP.
- R10: Read results do not depend on the level of `write_lock`.
- R11: After reset, SDA is released and the address counter is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronised serial clock line |
| sda_i | input | 1 | Synchronised serial data line as seen on the bus |
| chip_addr | input | 3 | Strap bits that the select byte must match |
| write_lock | input | 1 | 1 blocks storing of written data |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain) |

## Verification
A wrong protocol state shows up within one byte time as a missing or extra acknowledge, or as a misplaced data bit on SDA. A wrong address counter or a fault in the page buffer only shows when a later read returns the wrong byte. For that reason every write is read back through both random and current-address reads, including across the page and array wrap points. A busy timer of the wrong length is caught by polling with a select byte immediately after STOP and again after the expected window.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DEV,
        S_DEV_ACK,
        S_AHI,
        S_AHI_ACK,
        S_ALO,
        S_ALO_ACK,
        S_WDAT,
        S_WDAT_ACK,
        S_RDAT,
        S_RACK,
        S_SKIP
    } bus_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } line_evt_t;

    function automatic logic sel_match(input logic [7:0] b, input logic [2:0] strap);
        return (b[7:4] == DEV_TYPE) && (b[3:1] == strap);
    endfunction

endpackage

// File: rtl/ee_line_mon.sv
module ee_line_mon
    import eeprom_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      scl_i,
    input  logic      sda_i,
    output line_evt_t evt
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        evt.start = scl_q & scl_i & sda_q & ~sda_i;
        evt.stop  = scl_q & scl_i & ~sda_q & sda_i;
        evt.rise  = ~scl_q & scl_i;
        evt.fall  = scl_q & ~scl_i;
        evt.sda   = sda_i;
    end

endmodule

// File: rtl/ee_store.sv
module ee_store #(
    parameter int MEM_BYTES    = 512,
    parameter int PAGE_BYTES   = 64,
    parameter int WRITE_CYCLES = 300
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [$clog2(MEM_BYTES)-1:0]   rd_addr,
    output logic [7:0]                     rd_data,
    input  logic                           buf_we,
    input  logic [$clog2(PAGE_BYTES)-1:0]  buf_idx,
    input  logic [7:0]                     buf_data,
    input  logic                           buf_clr,
    input  logic                           commit,
    input  logic [$clog2(MEM_BYTES)-$clog2(PAGE_BYTES)-1:0] commit_page,
    output logic                           busy
);
    localparam int ADDR_W = $clog2(MEM_BYTES);
    localparam int PAGE_W = $clog2(PAGE_BYTES);
    localparam int PG_W   = ADDR_W - PAGE_W;
    localparam int TW     = $clog2(WRITE_CYCLES + 1);

    logic [7:0]            mem      [MEM_BYTES];
    logic [7:0]            page_buf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] valid;
    logic [TW-1:0]         timer;
    logic [PG_W-1:0]       page_q;
    logic [PAGE_W-1:0]     cidx;
    logic                  mem_we;

    assign cidx    = timer[PAGE_W-1:0];
    assign mem_we  = busy && (timer < TW'(PAGE_BYTES)) && valid[cidx];
    assign rd_data = mem[rd_addr];

    always_ff @(posedge clk) begin
        if (buf_we) page_buf[buf_idx] <= buf_data;
    end

    always_ff @(posedge clk) begin
        if (mem_we) mem[{page_q, cidx}] <= page_buf[cidx];
    end

    always_ff @(posedge clk) begin
        if (rst || buf_clr) valid <= '0;
        else if (buf_we)    valid[buf_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            timer  <= '0;
            page_q <= '0;
        end else if (commit) begin
            busy   <= 1'b1;
            timer  <= '0;
            page_q <= commit_page;
        end else if (busy) begin
            if (timer == TW'(WRITE_CYCLES - 1)) busy <= 1'b0;
            timer <= timer + 1'b1;
        end
    end

    AST_COMMIT_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        commit |-> !busy); // R4
    AST_BUSY_FROM_COMMIT: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(commit)); // R4

endmodule

// File: rtl/eeprom_target.sv
module eeprom_target
    import eeprom_pkg::*;
#(
    parameter int MEM_BYTES    = 512,
    parameter int PAGE_BYTES   = 64,
    parameter int WRITE_CYCLES = 300
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] chip_addr,
    input  logic       write_lock,
    output logic       sda_oe
);
    localparam int ADDR_W = $clog2(MEM_BYTES);
    localparam int PAGE_W = $clog2(PAGE_BYTES);
    localparam int HI_W   = ADDR_W - 8;

    line_evt_t         evt;
    bus_state_e        state;
    logic [3:0]        bitcnt;
    logic [7:0]        shreg;
    logic [7:0]        txbyte;
    logic              rw_q;
    logic              mack_q;
    logic              pend;
    logic [HI_W-1:0]   ahi_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        rd_data;
    logic              busy;
    logic              byte_end;
    logic              buf_we;
    logic              buf_clr;
    logic              commit;

    ee_line_mon u_mon (
        .clk (clk),
        .rst (rst),
        .scl_i(scl_i),
        .sda_i(sda_i),
        .evt (evt)
    );

    ee_store #(
        .MEM_BYTES   (MEM_BYTES),
        .PAGE_BYTES  (PAGE_BYTES),
        .WRITE_CYCLES(WRITE_CYCLES)
    ) u_store (
        .clk        (clk),
        .rst        (rst),
        .rd_addr    (addr_q),
        .rd_data    (rd_data),
        .buf_we     (buf_we),
        .buf_idx    (addr_q[PAGE_W-1:0]),
        .buf_data   (shreg),
        .buf_clr    (buf_clr),
        .commit     (commit),
        .commit_page(addr_q[ADDR_W-1:PAGE_W]),
        .busy       (busy)
    );

    assign byte_end = evt.fall && (bitcnt == 4'd8);
    assign buf_we   = (state == S_WDAT) && byte_end;
    assign buf_clr  = (state == S_ALO) && byte_end;
    assign commit   = evt.stop && pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            bitcnt <= '0;
            shreg  <= '0;
            txbyte <= '0;
            rw_q   <= 1'b0;
            mack_q <= 1'b0;
            pend   <= 1'b0;
            ahi_q  <= '0;
            addr_q <= '0;
            sda_oe <= 1'b0;
        end else if (evt.stop) begin
            state  <= S_IDLE;
            sda_oe <= 1'b0;
            pend   <= 1'b0;
        end else if (evt.start) begin
            state  <= S_DEV;
            bitcnt <= '0;
            sda_oe <= 1'b0;
            pend   <= 1'b0;
        end else begin
            unique case (state)
                S_DEV, S_AHI, S_ALO, S_WDAT: begin
                    if (evt.rise) begin
                        shreg  <= {shreg[6:0], evt.sda};
                        bitcnt <= bitcnt + 1'b1;
                    end
                    if (byte_end) begin
                        bitcnt <= '0;
                        sda_oe <= 1'b1;
                        case (state)
                            S_DEV: begin
                                if (sel_match(shreg, chip_addr) && !busy) begin
                                    rw_q  <= shreg[0];
                                    state <= S_DEV_ACK;
                                end else begin
                                    sda_oe <= 1'b0;
                                    state  <= S_SKIP;
                                end
                            end
                            S_AHI: begin
                                ahi_q <= shreg[HI_W-1:0];
                                state <= S_AHI_ACK;
                            end
                            S_ALO: begin
                                addr_q <= {ahi_q, shreg};
                                state  <= S_ALO_ACK;
                            end
                            default: begin
                                addr_q <= {addr_q[ADDR_W-1:PAGE_W], addr_q[PAGE_W-1:0] + 1'b1};
                                pend   <= pend | ~write_lock;
                                state  <= S_WDAT_ACK;
                            end
                        endcase
                    end
                end
                S_DEV_ACK, S_AHI_ACK, S_ALO_ACK, S_WDAT_ACK: begin
                    if (evt.fall) begin
                        sda_oe <= 1'b0;
                        bitcnt <= '0;
                        case (state)
                            S_DEV_ACK: begin
                                if (rw_q) begin
                                    txbyte <= rd_data;
                                    sda_oe <= ~rd_data[7];
                                    addr_q <= addr_q + 1'b1;
                                    state  <= S_RDAT;
                                end else begin
                                    state <= S_AHI;
                                end
                            end
                            S_AHI_ACK: state <= S_ALO;
                            default:   state <= S_WDAT;
                        endcase
                    end
                end
                S_RDAT: begin
                    if (evt.rise) bitcnt <= bitcnt + 1'b1;
                    if (evt.fall) begin
                        if (bitcnt == 4'd8) begin
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                            state  <= S_RACK;
                        end else begin
                            txbyte <= {txbyte[6:0], 1'b0};
                            sda_oe <= ~txbyte[6];
                        end
                    end
                end
                S_RACK: begin
                    if (evt.rise) mack_q <= ~evt.sda;
                    if (evt.fall) begin
                        if (mack_q) begin
                            txbyte <= rd_data;
                            sda_oe <= ~rd_data[7];
                            addr_q <= addr_q + 1'b1;
                            state  <= S_RDAT;
                        end else begin
                            state <= S_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    AST_NO_ACK_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (state == S_DEV_ACK) |-> !busy); // R4
    AST_DRIVE_ON_LOW_CLOCK: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_i); // R2
    AST_PAGE_KEPT: assert property (@(posedge clk) disable iff (rst)
        buf_we |=> (addr_q[ADDR_W-1:PAGE_W] == $past(addr_q[ADDR_W-1:PAGE_W]))); // R5
    AST_SKIP_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (state == S_SKIP) |-> !sda_oe); // R1

endmodule

// File: tb/eeprom_target_bench.sv
module eeprom_target_bench;
    localparam int WCYC = 300;
    localparam logic [2:0] STRAP = 3'b101;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic m_oe = 1'b0;
    logic lock = 1'b0;
    logic sda_oe;
    logic sda_line;
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    always #2.5 clk = ~clk;
    assign sda_line = ~(m_oe | sda_oe);

    eeprom_target #(.MEM_BYTES(512), .PAGE_BYTES(64), .WRITE_CYCLES(WCYC)) u_eeprom_target (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
        .chip_addr(STRAP), .write_lock(lock), .sda_oe(sda_oe)
    );

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        m_oe = 1'b0; hold(2);
        scl = 1'b1;  hold(4);
        m_oe = 1'b1; hold(4);
        scl = 1'b0;  hold(2);
    endtask

    task automatic bus_stop();
        m_oe = 1'b1; hold(2);
        scl = 1'b1;  hold(4);
        m_oe = 1'b0; hold(4);
    endtask

    task automatic put_bit(input logic b);
        m_oe = ~b;  hold(2);
        scl = 1'b1; hold(4);
        scl = 1'b0; hold(2);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        m_oe = 1'b0; hold(2);
        scl = 1'b1;  hold(2);
        ack = ~sda_line;
        hold(2);
        scl = 1'b0;  hold(2);
    endtask

    task automatic get_byte(input logic give_ack, output logic [7:0] d);
        m_oe = 1'b0;
        for (int i = 0; i < 8; i++) begin
            hold(2); scl = 1'b1; hold(2);
            d = {d[6:0], sda_line};
            hold(2); scl = 1'b0;
        end
        m_oe = give_ack; hold(2);
        scl = 1'b1; hold(4);
        scl = 1'b0; hold(2);
        m_oe = 1'b0;
    endtask

    function automatic logic [7:0] sel(input logic rw);
        return {4'b1010, STRAP, rw};
    endfunction

    task automatic addr_phase(input logic [15:0] a, input string req);
        logic ack;
        bus_start();
        send_byte(sel(1'b0), ack); check(ack, req, ack, 1);
        send_byte(a[15:8], ack);   check(ack, req, ack, 1);
        send_byte(a[7:0], ack);    check(ack, req, ack, 1);
    endtask

    task automatic read_from(input logic [15:0] a, input int n,
                             input logic [7:0] e0, input logic [7:0] e1, input string req);
        logic ack;
        logic [7:0] d;
        addr_phase(a, req);
        bus_start();
        send_byte(sel(1'b1), ack); check(ack, req, ack, 1);
        get_byte(n > 1, d);        check(d == e0, req, d, e0);
        if (n > 1) begin
            get_byte(1'b0, d);     check(d == e1, req, d, e1);
        end
        bus_stop();
    endtask

    task automatic t_reset();
        check(sda_oe == 1'b0, "R11", sda_oe, 0);
    endtask

    task automatic t_byte_write();
        logic ack;
        addr_phase(16'h0041, "R2");
        send_byte(8'h5A, ack); check(ack, "R2", ack, 1);
        bus_stop(); hold(WCYC + 20);
        read_from(16'h0041, 1, 8'h5A, 8'h00, "R6");
    endtask

    task automatic t_busy();
        logic ack;
        addr_phase(16'h0050, "R4");
        send_byte(8'h77, ack);
        bus_stop();
        bus_start(); send_byte(sel(1'b0), ack); check(!ack, "R4 busy", ack, 0); bus_stop();
        hold(WCYC + 20);
        bus_start(); send_byte(sel(1'b0), ack); check(ack, "R4 ready", ack, 1); bus_stop();
    endtask

    task automatic t_page();
        logic ack;
        addr_phase(16'h003E, "R5");
        send_byte(8'hA1, ack); send_byte(8'hB2, ack);
        send_byte(8'hC3, ack); send_byte(8'hD4, ack); check(ack, "R5", ack, 1);
        bus_stop(); hold(WCYC + 20);
        read_from(16'h003E, 2, 8'hA1, 8'hB2, "R5");
        read_from(16'h0000, 2, 8'hC3, 8'hD4, "R5");
    endtask

    task automatic t_current();
        logic ack;
        logic [7:0] d;
        read_from(16'h003E, 1, 8'hA1, 8'h00, "R7");
        bus_start(); send_byte(sel(1'b1), ack); check(ack, "R7", ack, 1);
        get_byte(1'b0, d); check(d == 8'hB2, "R7 current", d, 8'hB2);
        hold(4); check(sda_oe == 1'b0, "R9", sda_oe, 0);
        bus_stop();
    endtask

    task automatic t_wrap_read();
        logic ack;
        addr_phase(16'h01FF, "R8");
        send_byte(8'hEE, ack);
        bus_stop(); hold(WCYC + 20);
        read_from(16'h01FF, 2, 8'hEE, 8'hC3, "R8");
    endtask

    task automatic t_lock();
        logic ack;
        lock = 1'b1;
        addr_phase(16'h0041, "R3");
        send_byte(8'h99, ack); check(ack, "R3 ack", ack, 1);
        bus_stop();
        bus_start(); send_byte(sel(1'b0), ack); check(ack, "R3 no busy", ack, 1); bus_stop();
        read_from(16'h0041, 1, 8'h5A, 8'h00, "R10");
        lock = 1'b0;
    endtask

    task automatic t_mismatch();
        logic ack;
        bus_start();
        send_byte({4'b1010, 3'b001, 1'b0}, ack); check(!ack, "R1", ack, 0);
        send_byte(8'h00, ack); check(!ack, "R1 released", ack, 0);
        bus_stop();
        bus_start(); send_byte(sel(1'b0), ack); check(ack, "R1 match", ack, 1); bus_stop();
    endtask

    initial begin
        hold(5); rst = 1'b0; hold(5);
        t_reset();
        t_byte_write();
        t_busy();
        t_page();
        t_current();
        t_wrap_read();
        t_lock();
        t_mismatch();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule